// File: doc/BRIEF.md
# 32.768 kHz Free-Running Sync Counter

This peripheral keeps a 32-bit up-counter that advances once for every rising edge of a slow 32.768 kHz reference. The reference runs independently of the bus clock, so it is brought into the bus clock domain by a two-stage synchroniser. An edge detector after it turns each rising edge into a single one-cycle increment enable. Software sees the counter and a fixed revision word through a small read-only register window. Every bus request is answered exactly one clock later, either with data or with an error code.

Narrow 16-bit buses cannot read a 32-bit value in one access. A read of the lower half therefore copies the upper half of the same register into a holding register in the same clock edge. A later read of the upper half returns that copy and does not look at the live counter, so the two halves always belong to one sample. Writes, 8-bit accesses and unknown offsets are refused with an error and leave all state unchanged. The one exception is a lower-half read of an unknown offset, which loads zero into the holding register.

Top module: `sync32k_counter`

## Requirements
- R1: After reset the counter and the holding register are both zero, and no response is signalled.
- R2: The counter increases by exactly one for each rising edge of the reference input, with no other change, and wraps modulo 2^32 without signalling an error.
- R3: A 32-bit read (size code 2'b10) at offset 0x00 returns 0x00000021 with error code 2'b00.
- R4: A 32-bit read at offset 0x10 returns the counter value present at the clock edge that takes the request, with error code 2'b00.
- R5: A 16-bit read (size code 2'b01) with address bit 1 clear decodes the offset with its two low bits cleared. It returns the lower 16 bits of the addressed register, zero-extended, and in the same edge loads that register's upper 16 bits into the holding register.
- R6: A 16-bit read with address bit 1 set returns the holding register zero-extended with error code 2'b00. It leaves the holding register unchanged and returns the stored value even when the live counter's upper half has since moved on.
- R7: Any write request returns data 0 and an error code: 2'b01 (bad register) for 16- or 32-bit writes, 2'b10 for the other sizes. A write changes neither the counter nor the holding register.
- R8: A request with size code 2'b00 (8-bit) or 2'b11 returns data 0 with error code 2'b10 (bad width) and leaves the holding register unchanged.
- R9: A 32-bit read at any offset other than 0x00 or 0x10, or a lower-half 16-bit read at any other offset, returns data 0 with error code 2'b01. The 16-bit case also loads zero into the holding register.
- R10: `respValid` is high for exactly the cycle after each cycle in which a request is presented, and low after every idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| refClkIn | input | 1 | 32.768 kHz reference, asynchronous to clk |
| busAddr | input | ADDR_W | Byte offset within the register window |
| busRd | input | 1 | Read request strobe, one cycle per request |
| busWr | input | 1 | Write request strobe; a write always wins over a read |
| busSize | input | 2 | Access size: 00 = 8-bit, 01 = 16-bit, 10 = 32-bit, 11 = invalid |
| respValid | output | 1 | Response strobe, one cycle after a request |
| respData | output | 32 | Read data, zero on error |
| respErrKind | output | 2 | 00 = ok, 01 = bad register, 10 = bad width |

## Verification
Some properties are checked on every cycle. The counter must step by exactly one after each enable pulse and stay still otherwise, which also covers the silent wrap. An enable pulse can never be followed directly by another. Every request must be answered in the next cycle and no response may appear without one. Writes may never disturb the holding register, and error responses must always carry zero data. Only the bench scenarios can show the values themselves: that the counter tracks the number of reference edges, that the revision word reads correctly, and that a stale upper half is returned after the counter has crossed a 16-bit boundary between the two half reads. They also show that a lower-half read of an unknown offset clears the holding register.

// File: rtl/sync32k_pkg.sv
package sync32k_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } accSize_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'b00,
    ERR_REG   = 2'b01,
    ERR_WIDTH = 2'b10
  } errKind_e;

  // Strobes from the decode control into the datapath
  typedef struct packed {
    logic     respond;
    logic     selRev;
    logic     selCnt;
    logic     selHold;
    logic     half;
    logic     capHold;
    errKind_e errKind;
  } strobe_t;

endpackage

// File: rtl/sync32k_tick.sv
module sync32k_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic refIn,
  output logic tickPulse
);
  // synchroniser stages plus one history bit for the edge detector
  logic [SYNC_STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[SYNC_STAGES-1:0], refIn};
  end

  assign tickPulse = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];

endmodule

// File: rtl/sync32k_ctrl.sv
module sync32k_ctrl
  import sync32k_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter logic [7:0]  REV_OFS = 8'h00,
  parameter logic [7:0]  CNT_OFS = 8'h10
) (
  input  logic              busRd,
  input  logic              busWr,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  localparam logic [ADDR_W-1:0] REV_A = ADDR_W'(REV_OFS);
  localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(CNT_OFS);

  logic              access;
  logic              isHalf;
  logic              widthBad;
  logic [ADDR_W-1:0] wordAddr;

  always_comb begin
    access   = busRd | busWr;
    isHalf   = (accSize_e'(busSize) == SZ_HALF);
    widthBad = !(isHalf || accSize_e'(busSize) == SZ_WORD);
    wordAddr = isHalf ? {busAddr[ADDR_W-1:2], 2'b00} : busAddr;

    stb         = '0;
    stb.errKind = ERR_NONE;
    stb.respond = access;
    if (access) begin
      if (widthBad) begin
        stb.errKind = ERR_WIDTH;
      end else if (busWr) begin
        stb.errKind = ERR_REG;
      end else if (isHalf && busAddr[1]) begin
        stb.selHold = 1'b1;
      end else begin
        stb.half    = isHalf;
        stb.capHold = isHalf;
        if (wordAddr == REV_A)      stb.selRev  = 1'b1;
        else if (wordAddr == CNT_A) stb.selCnt  = 1'b1;
        else                        stb.errKind = ERR_REG;
      end
    end
  end

endmodule

// File: rtl/sync32k_dp.sv
module sync32k_dp
  import sync32k_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter logic [31:0] REV_VALUE = 32'h0000_0021
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickPulse,
  input  strobe_t           stb,
  output logic              respValid,
  output logic [DATA_W-1:0] respData,
  output logic [1:0]        respErrKind,
  output logic [DATA_W-1:0] cntVal,
  output logic [DATA_W/2-1:0] holdVal
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] word;

  always_comb begin
    if (stb.selRev)      word = DATA_W'(REV_VALUE);
    else if (stb.selCnt) word = cntVal;
    else                 word = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal      <= '0;
      holdVal     <= '0;
      respValid   <= 1'b0;
      respData    <= '0;
      respErrKind <= ERR_NONE;
    end else begin
      if (tickPulse) cntVal <= cntVal + 1'b1;
      respValid <= stb.respond;
      if (stb.respond) begin
        respErrKind <= stb.errKind;
        if (stb.selHold)   respData <= {{HALF_W{1'b0}}, holdVal};
        else if (stb.half) respData <= {{HALF_W{1'b0}}, word[HALF_W-1:0]};
        else               respData <= word;
      end
      if (stb.capHold) holdVal <= word[DATA_W-1:HALF_W];
    end
  end

endmodule

// File: rtl/sync32k_counter.sv
module sync32k_counter
  import sync32k_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  REV_OFS     = 8'h00,
  parameter logic [7:0]  CNT_OFS     = 8'h10,
  parameter logic [31:0] REV_VALUE   = 32'h0000_0021
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refClkIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [1:0]        busSize,
  output logic              respValid,
  output logic [31:0]       respData,
  output logic [1:0]        respErrKind
);
  localparam int DATA_W = 32;

  logic                tickPulse;
  strobe_t             stb;
  logic [DATA_W-1:0]   cntVal;
  logic [DATA_W/2-1:0] holdVal;

  sync32k_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rstN(rstN), .refIn(refClkIn), .tickPulse(tickPulse)
  );

  sync32k_ctrl #(.ADDR_W(ADDR_W), .REV_OFS(REV_OFS), .CNT_OFS(CNT_OFS)) u_ctrl (
    .busRd(busRd), .busWr(busWr), .busSize(busSize), .busAddr(busAddr), .stb(stb)
  );

  sync32k_dp #(.DATA_W(DATA_W), .REV_VALUE(REV_VALUE)) u_dp (
    .clk(clk), .rstN(rstN), .tickPulse(tickPulse), .stb(stb),
    .respValid(respValid), .respData(respData), .respErrKind(respErrKind),
    .cntVal(cntVal), .holdVal(holdVal)
  );

endmodule

// File: rtl/sync32k_checker.sv
module sync32k_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busRd,
  input logic        busWr,
  input logic [1:0]  busSize,
  input logic        respValid,
  input logic [31:0] respData,
  input logic [1:0]  respErrKind,
  input logic        tickPulse,
  input logic [31:0] cntVal,
  input logic [15:0] holdVal
);

  a_r10_resp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || busWr) |=> respValid);

  a_r10_no_idle_resp: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd || busWr) |=> !respValid);

  a_r2_step_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    tickPulse |=> cntVal == $past(cntVal) + 32'd1);

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    !tickPulse |=> $stable(cntVal));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    tickPulse |=> !tickPulse);

  a_r7_write_keeps_hold: assert property (@(posedge clk) disable iff (!rstN)
    busWr |=> $stable(holdVal));

  a_r8_width_error: assert property (@(posedge clk) disable iff (!rstN)
    ((busRd || busWr) && (busSize == 2'b00 || busSize == 2'b11)) |=> respErrKind == 2'b10);

  a_r9_error_zero_data: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respErrKind != 2'b00) |-> respData == 32'd0);

endmodule

bind sync32k_counter sync32k_checker u_chk (
  .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr), .busSize(busSize),
  .respValid(respValid), .respData(respData), .respErrKind(respErrKind),
  .tickPulse(tickPulse), .cntVal(cntVal), .holdVal(holdVal)
);

// File: tb/sync32k_counter_bench.sv
module sync32k_counter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refClkIn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [1:0]  busSize = 2'b10;
  logic        respValid;
  logic [31:0] respData;
  logic [1:0]  respErrKind;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int unsigned expCnt = 0;
  logic [15:0] expHold = '0;
  int unsigned seed = 32'h5EED_1234;

  always #4 clk = ~clk;

  sync32k_counter u_sync32k_counter (
    .clk(clk), .rstN(rstN), .refClkIn(refClkIn), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .busSize(busSize),
    .respValid(respValid), .respData(respData), .respErrKind(respErrKind)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Reference model of one request, from the requirements
  function automatic void model(input logic wr, input logic [1:0] sz, input logic [7:0] addr,
                                input logic [31:0] cnt, input logic [15:0] hold,
                                output logic [31:0] data, output logic [1:0] kind,
                                output logic [15:0] newHold);
    logic [31:0] word;
    logic        known;
    logic [7:0]  a;
    data = '0; kind = 2'b00; newHold = hold;
    a = (sz == 2'b01) ? {addr[7:2], 2'b00} : addr;
    known = (a == 8'h00) || (a == 8'h10);
    word = (a == 8'h00) ? 32'h21 : (a == 8'h10) ? cnt : 32'h0;
    if (sz == 2'b00 || sz == 2'b11) kind = 2'b10;
    else if (wr) kind = 2'b01;
    else if (sz == 2'b01 && addr[1]) data = {16'h0, hold};
    else begin
      if (!known) kind = 2'b01;
      if (sz == 2'b01) begin
        data = {16'h0, word[15:0]};
        newHold = word[31:16];
      end else data = word;
    end
  endfunction

  task automatic refEdges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) refClkIn = 1'b1;
      @(negedge clk) refClkIn = 1'b0;
      expCnt++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic access(input string req, input logic wr, input logic [1:0] sz, input logic [7:0] addr);
    logic [31:0] eData;
    logic [1:0]  eKind;
    logic [15:0] eHold;
    model(wr, sz, addr, expCnt, expHold, eData, eKind, eHold);
    @(negedge clk);
    busWr = wr; busRd = !wr; busSize = sz; busAddr = addr;
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0;
    chk({req, " R10 valid"}, {31'h0, respValid}, 32'd1);
    chk({req, " data"}, respData, eData);
    chk({req, " errkind"}, {30'h0, respErrKind}, {30'h0, eKind});
    expHold = eHold;
    @(negedge clk);
    chk("R10 idle", {31'h0, respValid}, 32'd0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 no resp in reset", {31'h0, respValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {31'h0, respValid}, 32'd0);
    access("R1 counter zero", 1'b0, 2'b10, 8'h10);
    access("R1 hold zero", 1'b0, 2'b01, 8'h12);
    access("R3 revision", 1'b0, 2'b10, 8'h00);
    access("R5 revision low half", 1'b0, 2'b01, 8'h00);
    refEdges(3);
    access("R2 R4 three edges", 1'b0, 2'b10, 8'h10);

    // long burst until just below a 16-bit boundary
    refEdges(65530 - int'(expCnt));
    access("R5 low half before boundary", 1'b0, 2'b01, 8'h10);
    refEdges(10);
    access("R6 stale upper half", 1'b0, 2'b01, 8'h12);
    access("R2 R4 count past boundary", 1'b0, 2'b10, 8'h10);
    access("R5 low half after boundary", 1'b0, 2'b01, 8'h10);
    access("R6 upper half captured", 1'b0, 2'b01, 8'h12);
    access("R7 word write", 1'b1, 2'b10, 8'h10);
    access("R7 half write", 1'b1, 2'b01, 8'h12);
    access("R7 hold after write", 1'b0, 2'b01, 8'h12);
    access("R7 count after write", 1'b0, 2'b10, 8'h10);
    access("R8 byte read", 1'b0, 2'b00, 8'h10);
    access("R8 size code 3", 1'b0, 2'b11, 8'h00);
    access("R8 hold after byte", 1'b0, 2'b01, 8'h12);
    access("R9 word unknown", 1'b0, 2'b10, 8'h12);
    access("R9 word unknown 2", 1'b0, 2'b10, 8'h04);
    access("R9 half unknown", 1'b0, 2'b01, 8'h20);
    access("R9 hold cleared", 1'b0, 2'b01, 8'h12);

    // constrained random mix
    void'($urandom(seed));
    for (int i = 0; i < 300; i++) begin
      int unsigned pick = $urandom % 8;
      logic [7:0]  addr;
      logic [1:0]  sz;
      logic        wr;
      if (($urandom % 3) == 0) refEdges($urandom % 4);
      case (pick)
        0, 1: addr = 8'h10;
        2:    addr = 8'h12;
        3:    addr = 8'h00;
        4:    addr = 8'h02;
        default: addr = 8'($urandom);
      endcase
      sz = (($urandom % 4) == 0) ? 2'($urandom) : ((($urandom % 2) == 0) ? 2'b01 : 2'b10);
      wr = (($urandom % 8) == 0);
      access("R5 R6 R7 R8 R9 random", wr, sz, addr);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule